// File: doc/BRIEF.md
# Graphics DRAM Power-Up Initialization Sequencer

This block owns the reset, clock-enable and command pins of a graphics-class DDR SDRAM from the moment supply power is reported good until the memory can accept normal traffic. It first keeps the device in reset for a power-settling interval. It then places the wanted termination-strength level on CKE and lets the device leave reset while that level is held. After the clock-stabilization interval it plays a fixed command script: two all-bank precharges, three mode-register loads (a throw-away load with a fixed code, an extended load that turns the DLL on, a main load that resets the DLL and sets the operating parameters) and a burst of auto-refreshes. Each command is followed by its timing gap. `init_done` rises once the refresh gap and the DLL lock window have both run out.

Every interval is a parameter in clock cycles. A memory controller instantiates the block next to its command path and hands the pins over once `init_done` is high. Pulling `pwr_good` low or asserting `rst` aborts any stage and starts again from the beginning.

Pins are registered. Below, "cycle 0" is the cycle that begins at the rising edge after the edge that first samples `pwr_good` high (with `rst` low). Command encoding on `dram_cmd` is {cs_n, ras_n, cas_n, we_n}.

Top module: `gdram_init_seq`

## Requirements
- R1: Two rising edges after `rst` is sampled high, the pins read `dram_rst_n`=0, `dram_cke`=0, `dram_cmd`=4'b1111 (deselect), `init_done`=0. They stay that way while `rst` is high, and also while `pwr_good` stays low.
- R2: Command codes: deselect 4'b1111, NOP 4'b0111, precharge 4'b0010, mode load 4'b0000, auto-refresh 4'b0001. A precharge drives `dram_ba`=0 and `dram_addr` with only bit 8 set (all banks).
- R3: In cycles 0 to T_PWR-1, `dram_rst_n` and `dram_cke` are 0. In cycles 0 to T_STAB-1 the command is deselect.
- R4: Cycle T_STAB carries a NOP. `dram_rst_n` rises in cycle T_STAB+1. From cycle T_PWR up to cycle T_STAB+T_CKEH, `dram_cke` equals `cke_term_sel`, so it is held on both sides of the reset release.
- R5: The first precharge appears in cycle P1 = T_STAB+1+T_CKEH. `dram_cke` is 1 from that cycle on.
- R6: Mode loads follow in order. At P1+T_RP comes the throw-away load (`dram_ba`=00, `dram_addr`=14'b00001000100001). T_MRD later comes the extended load (`dram_ba`=01, `dram_addr`=`emr_code`). T_MRD after that comes the main load, cycle M (`dram_ba`=00, `dram_addr`=`mr_code`).
- R7: The second precharge comes at M+T_MRD. T_RP after it comes the first of N_REF auto-refreshes, and the refreshes are spaced T_RFC apart.
- R8: Every command lasts exactly one cycle. Every other cycle from T_STAB onward is a NOP.
- R9: `init_done` first rises in cycle max(last refresh + T_RFC, M + T_DLL), never less than T_DLL cycles after the main load.
- R10: Once high, `init_done` stays high while `pwr_good` stays high and `rst` stays low.
- R11: A drop of `pwr_good` at any stage returns the pins to the R1 state within two edges. The whole sequence restarts from cycle 0 when `pwr_good` returns.
- R12: A `rst` pulse after completion clears `init_done` and the sequence replays in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply and clock reported stable |
| cke_term_sel | input | 1 | CKE level held across reset release (0 half, 1 full termination strength) |
| mr_code | input | ADDR_W | Operating-parameter code for the main mode load |
| emr_code | input | ADDR_W | Code for the extended mode load (DLL enable) |
| dram_cmd | output | 4 | Encoded {cs_n, ras_n, cas_n, we_n} |
| dram_ba | output | 2 | Bank address |
| dram_addr | output | ADDR_W | Address bus |
| dram_rst_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Device clock enable |
| init_done | output | 1 | Initialization complete |

## Verification
The checks assume that `cke_term_sel`, `mr_code` and `emr_code` are static configuration: they are set before `pwr_good` rises and do not move until the sequence ends. The stimulus changes them only while the block sits in its off state. The DLL-window property also assumes that only this block issues mode loads, so it measures the gap from the last one it sees. The bench changes `pwr_good` and `rst` only on falling clock edges, and it removes power in the middle of the command script to reach the abort path.

// File: rtl/gdram_init_pkg.sv
package gdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_PRE   = 4'b0010,
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001
    } dram_cmd_e;

    typedef enum logic [4:0] {
        ST_OFF,
        ST_PWR,
        ST_STAB,
        ST_NOP,
        ST_RHOLD,
        ST_PRE1,
        ST_W_RP1,
        ST_DMRS,
        ST_W_MRD1,
        ST_EMRS,
        ST_W_MRD2,
        ST_MRS,
        ST_W_MRD3,
        ST_PRE2,
        ST_W_RP2,
        ST_REF,
        ST_W_RFC,
        ST_DLL,
        ST_DONE
    } init_state_e;

    localparam int          CODE_W        = 14;
    localparam logic [13:0] DUMMY_MR_CODE = 14'b00001000100001;
    localparam int          PRE_ALL_BIT   = 8;
    localparam logic [1:0]  BA_MAIN_MR    = 2'b00;
    localparam logic [1:0]  BA_EXT_MR     = 2'b01;

    typedef struct packed {
        dram_cmd_e  cmd;
        logic [1:0] ba;
        logic       rst_n;
        logic       cke;
        logic       done;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_OFF = '{cmd: CMD_DESEL, ba: 2'b00, rst_n: 1'b0,
                                      cke: 1'b0, done: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic dram_cmd_e state_cmd(input init_state_e s);
        case (s)
            ST_OFF, ST_PWR, ST_STAB: return CMD_DESEL;
            ST_PRE1, ST_PRE2:        return CMD_PRE;
            ST_DMRS, ST_EMRS, ST_MRS: return CMD_MRS;
            ST_REF:                  return CMD_REF;
            default:                 return CMD_NOP;
        endcase
    endfunction

    function automatic logic state_after_reset(input init_state_e s);
        return !(s inside {ST_OFF, ST_PWR, ST_STAB, ST_NOP});
    endfunction

endpackage

// File: rtl/gdram_init_timer.sv
module gdram_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/gdram_init_fsm.sv
module gdram_init_fsm
    import gdram_init_pkg::*;
#(
    parameter int T_PWR  = 20000,
    parameter int T_STAB = 40000,
    parameter int T_CKEH = 4,
    parameter int T_MRD  = 6,
    parameter int T_RP   = 6,
    parameter int T_RFC  = 20,
    parameter int N_REF  = 2,
    parameter int CNT_W  = 16,
    parameter int REF_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic             step_zero,
    input  logic             dll_zero,
    output init_state_e      state,
    output logic             step_load,
    output logic [CNT_W-1:0] step_val,
    output logic             dll_load
);

    // A stage of D cycles loads D-1; a command spacing of S cycles
    // spends one cycle on the issue and loads S-2 for the wait.
    localparam logic [CNT_W-1:0] LD_PWR  = CNT_W'(T_PWR - 1);
    localparam logic [CNT_W-1:0] LD_STAB = CNT_W'(T_STAB - T_PWR - 1);
    localparam logic [CNT_W-1:0] LD_CKEH = CNT_W'(T_CKEH - 1);
    localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 2);
    localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 2);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF);

    init_state_e      nxt;
    logic [REF_W-1:0] ref_cnt;

    always_comb begin
        nxt       = state;
        step_load = 1'b0;
        step_val  = '0;
        dll_load  = 1'b0;
        case (state)
            ST_OFF: begin
                nxt       = ST_PWR;
                step_load = 1'b1;
                step_val  = LD_PWR;
            end
            ST_PWR: begin
                if (step_zero) begin
                    nxt       = ST_STAB;
                    step_load = 1'b1;
                    step_val  = LD_STAB;
                end
            end
            ST_STAB: begin
                if (step_zero) nxt = ST_NOP;
            end
            ST_NOP: begin
                nxt       = ST_RHOLD;
                step_load = 1'b1;
                step_val  = LD_CKEH;
            end
            ST_RHOLD: begin
                if (step_zero) nxt = ST_PRE1;
            end
            ST_PRE1: begin
                nxt       = ST_W_RP1;
                step_load = 1'b1;
                step_val  = LD_RP;
            end
            ST_W_RP1: begin
                if (step_zero) nxt = ST_DMRS;
            end
            ST_DMRS: begin
                nxt       = ST_W_MRD1;
                step_load = 1'b1;
                step_val  = LD_MRD;
            end
            ST_W_MRD1: begin
                if (step_zero) nxt = ST_EMRS;
            end
            ST_EMRS: begin
                nxt       = ST_W_MRD2;
                step_load = 1'b1;
                step_val  = LD_MRD;
            end
            ST_W_MRD2: begin
                if (step_zero) nxt = ST_MRS;
            end
            ST_MRS: begin
                nxt       = ST_W_MRD3;
                step_load = 1'b1;
                step_val  = LD_MRD;
                dll_load  = 1'b1;
            end
            ST_W_MRD3: begin
                if (step_zero) nxt = ST_PRE2;
            end
            ST_PRE2: begin
                nxt       = ST_W_RP2;
                step_load = 1'b1;
                step_val  = LD_RP;
            end
            ST_W_RP2: begin
                if (step_zero) nxt = ST_REF;
            end
            ST_REF: begin
                nxt       = ST_W_RFC;
                step_load = 1'b1;
                step_val  = LD_RFC;
            end
            ST_W_RFC: begin
                if (step_zero) begin
                    if (ref_cnt < REF_LAST) nxt = ST_REF;
                    else if (dll_zero)      nxt = ST_DONE;
                    else                    nxt = ST_DLL;
                end
            end
            ST_DLL: begin
                if (dll_zero) nxt = ST_DONE;
            end
            ST_DONE: begin
                nxt = ST_DONE;
            end
            default: begin
                nxt = ST_OFF;
            end
        endcase
        if (!pwr_good) begin
            nxt       = ST_OFF;
            step_load = 1'b0;
            dll_load  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            ref_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_OFF || nxt == ST_PRE2) begin
                ref_cnt <= '0;
            end else if (state == ST_REF) begin
                ref_cnt <= ref_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gdram_init_pins.sv
module gdram_init_pins
    import gdram_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_e       state,
    input  logic              cke_term_sel,
    input  logic [ADDR_W-1:0] mr_code,
    input  logic [ADDR_W-1:0] emr_code,
    output pin_ctl_t          pins,
    output logic [ADDR_W-1:0] addr
);

    pin_ctl_t          pins_n;
    logic [ADDR_W-1:0] addr_n;

    always_comb begin
        pins_n.cmd   = state_cmd(state);
        pins_n.ba    = 2'b00;
        pins_n.rst_n = state_after_reset(state);
        pins_n.done  = (state == ST_DONE);
        case (state)
            ST_OFF, ST_PWR:            pins_n.cke = 1'b0;
            ST_STAB, ST_NOP, ST_RHOLD: pins_n.cke = cke_term_sel;
            default:                   pins_n.cke = 1'b1;
        endcase

        addr_n = '0;
        case (state)
            ST_PRE1, ST_PRE2: begin
                addr_n[PRE_ALL_BIT] = 1'b1;
            end
            ST_DMRS: begin
                pins_n.ba = BA_MAIN_MR;
                addr_n    = ADDR_W'(DUMMY_MR_CODE);
            end
            ST_EMRS: begin
                pins_n.ba = BA_EXT_MR;
                addr_n    = emr_code;
            end
            ST_MRS: begin
                pins_n.ba = BA_MAIN_MR;
                addr_n    = mr_code;
            end
            default: begin
                addr_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= PINS_OFF;
            addr <= '0;
        end else begin
            pins <= pins_n;
            addr <= addr_n;
        end
    end

endmodule

// File: rtl/gdram_init_seq.sv
module gdram_init_seq
    import gdram_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int T_PWR  = 20000,
    parameter int T_STAB = 40000,
    parameter int T_CKEH = 4,
    parameter int T_MRD  = 6,
    parameter int T_RP   = 6,
    parameter int T_RFC  = 20,
    parameter int T_DLL  = 20000,
    parameter int N_REF  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              cke_term_sel,
    input  logic [ADDR_W-1:0] mr_code,
    input  logic [ADDR_W-1:0] emr_code,
    output logic [3:0]        dram_cmd,
    output logic [1:0]        dram_ba,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_rst_n,
    output logic              dram_cke,
    output logic              init_done
);

    localparam int LONGEST = imax(imax(T_STAB, T_DLL),
                                  imax(imax(T_RFC, T_RP), imax(T_MRD, T_CKEH)));
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int REF_W   = $clog2(N_REF + 1);
    localparam logic [CNT_W-1:0] LD_DLL = CNT_W'(T_DLL - 2);

    init_state_e      state;
    logic             step_load;
    logic [CNT_W-1:0] step_val;
    logic             step_zero;
    logic             dll_load;
    logic             dll_zero;
    pin_ctl_t         pins;

    gdram_init_fsm #(
        .T_PWR (T_PWR),
        .T_STAB(T_STAB),
        .T_CKEH(T_CKEH),
        .T_MRD (T_MRD),
        .T_RP  (T_RP),
        .T_RFC (T_RFC),
        .N_REF (N_REF),
        .CNT_W (CNT_W),
        .REF_W (REF_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .step_zero(step_zero),
        .dll_zero (dll_zero),
        .state    (state),
        .step_load(step_load),
        .step_val (step_val),
        .dll_load (dll_load)
    );

    gdram_init_timer #(.CNT_W(CNT_W)) u_step_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (step_load),
        .load_val(step_val),
        .expired (step_zero)
    );

    gdram_init_timer #(.CNT_W(CNT_W)) u_dll_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (dll_load),
        .load_val(LD_DLL),
        .expired (dll_zero)
    );

    gdram_init_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .cke_term_sel(cke_term_sel),
        .mr_code     (mr_code),
        .emr_code    (emr_code),
        .pins        (pins),
        .addr        (dram_addr)
    );

    assign dram_cmd   = pins.cmd;
    assign dram_ba    = pins.ba;
    assign dram_rst_n = pins.rst_n;
    assign dram_cke   = pins.cke;
    assign init_done  = pins.done;

endmodule

// File: rtl/gdram_init_chk.sv
module gdram_init_chk #(
    parameter int ADDR_W = 14,
    parameter int T_DLL  = 20000
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_good,
    input logic              cke_term_sel,
    input logic [3:0]        dram_cmd,
    input logic [1:0]        dram_ba,
    input logic [ADDR_W-1:0] dram_addr,
    input logic              dram_rst_n,
    input logic              dram_cke,
    input logic              init_done
);

    localparam int GAP_W = $clog2(T_DLL + 1);

    logic             exec_cmd;
    logic             main_load;
    logic             seen_load;
    logic [GAP_W-1:0] since_load;

    assign exec_cmd  = (dram_cmd != 4'b0111) && (dram_cmd != 4'b1111);
    assign main_load = (dram_cmd == 4'b0000) && (dram_ba == 2'b00);

    always_ff @(posedge clk) begin
        if (rst || !dram_rst_n) begin
            seen_load  <= 1'b0;
            since_load <= '0;
        end else if (main_load) begin
            seen_load  <= 1'b1;
            since_load <= GAP_W'(1);
        end else if (since_load < GAP_W'(T_DLL)) begin
            since_load <= since_load + 1'b1;
        end
    end

    assert_reset_pins_R1: assert property (@(posedge clk)
        rst |=> ##1 (!dram_rst_n && !dram_cke && !init_done && dram_cmd == 4'b1111));

    assert_power_loss_R11: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> ##1 (!dram_rst_n && !dram_cke && !init_done));

    assert_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
        !dram_rst_n |-> (dram_cmd == 4'b1111 || dram_cmd == 4'b0111));

    assert_cke_at_release_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_rst_n) |-> (dram_cke == $past(cke_term_sel)));

    assert_cmd_needs_cke_R5: assert property (@(posedge clk) disable iff (rst)
        exec_cmd |-> (dram_rst_n && dram_cke));

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (exec_cmd && $past(pwr_good) && !$past(rst)) |=> (dram_cmd == 4'b0111));

    assert_dll_window_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (seen_load && since_load >= GAP_W'(T_DLL)));

    assert_done_pins_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (dram_rst_n && dram_cke && dram_cmd == 4'b0111));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (init_done && pwr_good && $past(pwr_good) && !$past(rst)) |=> init_done);

endmodule

bind gdram_init_seq gdram_init_chk #(
    .ADDR_W(ADDR_W),
    .T_DLL (T_DLL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .cke_term_sel(cke_term_sel),
    .dram_cmd    (dram_cmd),
    .dram_ba     (dram_ba),
    .dram_addr   (dram_addr),
    .dram_rst_n  (dram_rst_n),
    .dram_cke    (dram_cke),
    .init_done   (init_done)
);

// File: tb/gdram_init_seq_test.sv
`timescale 1ns/1ps
module gdram_init_seq_test;

    localparam int ADDR_W = 14;
    localparam int T_PWR  = 20;
    localparam int T_STAB = 50;
    localparam int T_CKEH = 3;
    localparam int T_MRD  = 4;
    localparam int T_RP   = 5;
    localparam int T_RFC  = 8;
    localparam int T_DLL  = 60;
    localparam int N_REF  = 3;

    // Expected command cycles, counted from cycle 0
    localparam int P1    = T_STAB + 1 + T_CKEH;
    localparam int DM    = P1 + T_RP;
    localparam int EM    = DM + T_MRD;
    localparam int MR    = EM + T_MRD;
    localparam int P2    = MR + T_MRD;
    localparam int RF0   = P2 + T_RP;
    localparam int RFL   = RF0 + (N_REF - 1) * T_RFC;
    localparam int DONE  = ((RFL + T_RFC) > (MR + T_DLL)) ? (RFL + T_RFC) : (MR + T_DLL);
    localparam int WDOG  = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              pwr_good;
    logic              cke_term_sel;
    logic [ADDR_W-1:0] mr_code;
    logic [ADDR_W-1:0] emr_code;
    logic [3:0]        dram_cmd;
    logic [1:0]        dram_ba;
    logic [ADDR_W-1:0] dram_addr;
    logic              dram_rst_n;
    logic              dram_cke;
    logic              init_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2.5 clk = ~clk;

    gdram_init_seq #(
        .ADDR_W(ADDR_W), .T_PWR(T_PWR), .T_STAB(T_STAB), .T_CKEH(T_CKEH),
        .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .T_DLL(T_DLL), .N_REF(N_REF)
    ) uut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .cke_term_sel(cke_term_sel),
        .mr_code(mr_code), .emr_code(emr_code), .dram_cmd(dram_cmd),
        .dram_ba(dram_ba), .dram_addr(dram_addr), .dram_rst_n(dram_rst_n),
        .dram_cke(dram_cke), .init_done(init_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s at t=%0t: got %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic chk_off(input string req);
        chk(dram_rst_n == 1'b0, req, dram_rst_n, 0);
        chk(dram_cke == 1'b0, req, dram_cke, 0);
        chk(dram_cmd == 4'b1111, req, dram_cmd, 4'b1111);
        chk(init_done == 1'b0, req, init_done, 0);
    endtask

    // Caller stands at a falling edge with the block in its off state.
    task automatic run_seq(input logic sel, input logic [ADDR_W-1:0] mr,
                           input logic [ADDR_W-1:0] emr, input int stop_at);
        int last;
        cke_term_sel = sel;
        mr_code      = mr;
        emr_code     = emr;
        pwr_good     = 1'b1;
        @(negedge clk);
        chk(dram_rst_n == 1'b0, "R3", dram_rst_n, 0);
        last = (stop_at >= 0) ? stop_at : DONE + 3;
        for (int k = 0; k <= last; k++) begin
            logic [3:0]        ec;
            logic [1:0]        eba;
            logic [ADDR_W-1:0] ea;
            bit                use_addr;
            string             tag;
            logic              ecke;
            @(negedge clk);
            eba = 2'b00; ea = '0; use_addr = 1'b0;
            if (k < T_STAB) begin
                ec = 4'b1111; tag = "R3";
            end else if (k == T_STAB) begin
                ec = 4'b0111; tag = "R4";
            end else if (k == P1 || k == P2) begin
                ec = 4'b0010; ea = ADDR_W'(1) << 8; use_addr = 1'b1;
                tag = (k == P1) ? "R5" : "R7";
            end else if (k == DM) begin
                ec = 4'b0000; ea = 14'b00001000100001; use_addr = 1'b1; tag = "R6";
            end else if (k == EM) begin
                ec = 4'b0000; eba = 2'b01; ea = emr; use_addr = 1'b1; tag = "R6";
            end else if (k == MR) begin
                ec = 4'b0000; ea = mr; use_addr = 1'b1; tag = "R6";
            end else if (k >= RF0 && k <= RFL && ((k - RF0) % T_RFC) == 0) begin
                ec = 4'b0001; tag = "R7";
            end else begin
                ec = 4'b0111; tag = "R8";
            end
            chk(dram_cmd == ec, tag, dram_cmd, ec);
            if (use_addr) begin
                chk(dram_ba == eba, "R2", dram_ba, eba);
                chk(dram_addr == ea, "R2", dram_addr, ea);
            end
            chk(dram_rst_n == (k >= T_STAB + 1), "R4", dram_rst_n, k >= T_STAB + 1);
            ecke = (k < T_PWR) ? 1'b0 : (k < P1) ? sel : 1'b1;
            chk(dram_cke == ecke, (k < T_PWR) ? "R3" : (k < P1) ? "R4" : "R5",
                dram_cke, ecke);
            chk(init_done == (k >= DONE), "R9", init_done, k >= DONE);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; pwr_good = 1'b0; cke_term_sel = 1'b0;
        mr_code = '0; emr_code = '0;
        repeat (3) @(negedge clk);
        chk_off("R1");
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk_off("R1");
        end
    endtask

    task automatic t_hold;
        repeat (25) begin
            @(negedge clk);
            chk(init_done == 1'b1, "R10", init_done, 1);
            chk(dram_cmd == 4'b0111, "R8", dram_cmd, 4'b0111);
        end
    endtask

    task automatic t_pwr_drop;
        pwr_good = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_off("R11");
        repeat (3) begin
            @(negedge clk);
            chk_off("R11");
        end
    endtask

    task automatic t_rst_restart;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_off("R12");
        rst = 1'b0;
        run_seq(1'b0, 14'h0A5C, 14'h1003, -1);
        chk(init_done == 1'b1, "R12", init_done, 1);
    endtask

    initial begin
        t_reset();
        run_seq(1'b0, 14'h0163, 14'h0040, -1);
        t_hold();
        t_pwr_drop();
        run_seq(1'b1, 14'h2AB1, 14'h3FFE, MR + 6);
        t_pwr_drop();
        run_seq(1'b1, 14'h1357, 14'h0002, -1);
        t_hold();
        t_pwr_drop();
        run_seq(1'b0, 14'h0001, 14'h0000, T_STAB + 2);
        t_pwr_drop();
        run_seq(1'b1, 14'h0F0F, 14'h2001, -1);
        t_rst_restart();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule